// File: doc/BRIEF.md
# Event Interrupt Mask Controller

This block collects five single-cycle event pulses from a peripheral into sticky status bits. It raises one level-sensitive interrupt request while any latched event has its enable bit set. Software works through a small word-addressed register bus. There is a read-only status view and a write-only command for clearing status. The enable mask is changed only by two write-only strobe registers, one that sets enable bits and one that clears them. A read-only view shows the current mask.

Every enable change uses write-one semantics. Two agents that touch different sources therefore never need a read-modify-write of a shared mask. For the same reason, clearing one status bit cannot lose an event that arrives on another bit. The block has no state machine. The status and mask registers are its only state, one flip-flop per source in each.

Top module: `evtirq_ctl`

## Requirements
- R1: After a synchronous active-low reset, every status bit and every mask bit is zero and `irq_o` is low.
- R2: A high level on `src_pulse[i]` at a clock edge sets status bit i. The bit stays set until it is cleared. The source order is: bit 0 update acknowledge, bit 1 alarm, bit 2 second tick, bit 3 time match, bit 4 calendar match.
- R3: A write to offset 1 (status clear) clears each status bit whose data bit is one. Status bits whose data bit is zero keep their value.
- R4: If an event pulse and a status-clear write hit the same bit in the same cycle, the bit ends up set.
- R5: A write to offset 2 (enable set) sets each mask bit whose data bit is one. Zeros leave the mask unchanged.
- R6: A write to offset 3 (enable clear) clears each mask bit whose data bit is one. Zeros leave the mask unchanged.
- R7: Offset 4 reads the mask in bits 4:0. A write to offset 4 changes nothing.
- R8: `irq_o` is high exactly when some status bit and its mask bit are both one. It follows the registers in the cycle after the edge that changed them.
- R9: Bits 31:5 of every read are zero. Reads of offsets 1, 2, 3 and of offsets 5 to 7 return zero. Writes to offsets 5 to 7 change nothing.
- R10: Offset 0 reads the status in bits 4:0. A write to offset 0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Write strobe; a write takes effect at the rising edge |
| bus_addr | input | 3 | Word offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| src_pulse | input | 5 | Event pulses, one per source |
| irq_o | output | 1 | Level interrupt request |

## Verification
The assertions assume the event inputs and bus signals are settled at each rising edge. They also assume an event pulse may overlap a clear write to the same bit, and they expect the set to win in that case. The bench changes every input at the falling edge, so nothing switches near the active edge. Its random phase lets writes, offsets and pulses collide freely, so the collision cases the properties cover do get exercised.

// File: rtl/evtirq_pkg.sv
package evtirq_pkg;
    localparam int NSRC   = 5;
    localparam int ADDR_W = 3;

    localparam int SRC_UPD_ACK = 0;
    localparam int SRC_ALARM   = 1;
    localparam int SRC_SECOND  = 2;
    localparam int SRC_TIME    = 3;
    localparam int SRC_CAL     = 4;

    typedef enum logic [ADDR_W-1:0] {
        OFS_STATUS = 3'd0,
        OFS_STCLR  = 3'd1,
        OFS_ENSET  = 3'd2,
        OFS_ENCLR  = 3'd3,
        OFS_MASK   = 3'd4
    } reg_ofs_e;
endpackage

// File: rtl/evt_status_bank.sv
module evt_status_bank #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_pulse,
    input  logic         clr_stb,
    input  logic [N-1:0] clr_bits,
    output logic [N-1:0] sts_q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)
                sts_q[i] <= 1'b0;
            else if (set_pulse[i])
                sts_q[i] <= 1'b1;
            else if (clr_stb && clr_bits[i])
                sts_q[i] <= 1'b0;
        end

        // R2
        evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set_pulse[i] |=> sts_q[i]);
        // R2
        sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (sts_q[i] && !(clr_stb && clr_bits[i])) |=> sts_q[i]);
        // R3
        clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_stb && clr_bits[i] && !set_pulse[i]) |=> !sts_q[i]);
        // R4
        event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_stb && clr_bits[i] && set_pulse[i]) |=> sts_q[i]);
    end
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_stb,
    input  logic         clr_stb,
    input  logic [N-1:0] bits,
    output logic [N-1:0] msk_q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)
                msk_q[i] <= 1'b0;
            else if (set_stb && bits[i])
                msk_q[i] <= 1'b1;
            else if (clr_stb && bits[i])
                msk_q[i] <= 1'b0;
        end

        // R5
        mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (set_stb && bits[i]) |=> msk_q[i]);
        // R6
        mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_stb && !set_stb && bits[i]) |=> !msk_q[i]);
        // R5
        mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(bits[i] && (set_stb || clr_stb)) |=> $stable(msk_q[i]));
    end
endmodule

// File: rtl/evtirq_regif.sv
module evtirq_regif
    import evtirq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AW     = ADDR_W,
    parameter int N      = NSRC
) (
    input  logic              bus_wr,
    input  logic [AW-1:0]     bus_addr,
    input  logic [N-1:0]      sts_q,
    input  logic [N-1:0]      msk_q,
    output logic              stclr_stb,
    output logic              enset_stb,
    output logic              enclr_stb,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        stclr_stb = 1'b0;
        enset_stb = 1'b0;
        enclr_stb = 1'b0;
        rdata     = '0;
        case (bus_addr)
            OFS_STATUS: rdata[N-1:0] = sts_q;
            OFS_STCLR:  stclr_stb    = bus_wr;
            OFS_ENSET:  enset_stb    = bus_wr;
            OFS_ENCLR:  enclr_stb    = bus_wr;
            OFS_MASK:   rdata[N-1:0] = msk_q;
            default:    rdata        = '0;
        endcase
    end
endmodule

// File: rtl/evtirq_ctl.sv
module evtirq_ctl
    import evtirq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AW     = ADDR_W,
    parameter int N      = NSRC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [AW-1:0]     bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [N-1:0]      src_pulse,
    output logic              irq_o
);
    logic [N-1:0] sts_q;
    logic [N-1:0] msk_q;
    logic         stclr_stb;
    logic         enset_stb;
    logic         enclr_stb;

    evtirq_regif #(.DATA_W(DATA_W), .AW(AW), .N(N)) u_regif (
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .sts_q     (sts_q),
        .msk_q     (msk_q),
        .stclr_stb (stclr_stb),
        .enset_stb (enset_stb),
        .enclr_stb (enclr_stb),
        .rdata     (bus_rdata)
    );

    evt_status_bank #(.N(N)) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_pulse (src_pulse),
        .clr_stb   (stclr_stb),
        .clr_bits  (bus_wdata[N-1:0]),
        .sts_q     (sts_q)
    );

    irq_mask_bank #(.N(N)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_stb (enset_stb),
        .clr_stb (enclr_stb),
        .bits    (bus_wdata[N-1:0]),
        .msk_q   (msk_q)
    );

    assign irq_o = |(sts_q & msk_q);

    // R8
    irq_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past((src_pulse != '0) || enset_stb));
    // R8
    irq_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_o) |-> $past(stclr_stb || enclr_stb));
endmodule

// File: tb/test_evtirq_ctl.sv
module test_evtirq_ctl;
    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [4:0]  src_pulse = '0;
    logic        irq_o;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 1'b0;
    string req = "R1";

    int unsigned ref_sts = 0;
    int unsigned ref_msk = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    evtirq_ctl i_evtirq_ctl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_pulse(src_pulse), .irq_o(irq_o)
    );

    // behavioural reference, updated at every active edge
    always @(posedge clk) begin
        int unsigned s;
        int unsigned m;
        s = ref_sts;
        m = ref_msk;
        if (!rst_n) begin
            s = 0;
            m = 0;
        end else begin
            if (bus_wr && bus_addr == 3'd1) s = s & ~(bus_wdata & 32'h1f);
            s = s | src_pulse;
            if (bus_wr && bus_addr == 3'd2) m = m | (bus_wdata & 32'h1f);
            if (bus_wr && bus_addr == 3'd3) m = m & ~(bus_wdata & 32'h1f);
        end
        ref_sts <= s;
        ref_msk <= m;
    end

    task automatic compare();
        int unsigned exp_rd;
        logic exp_irq;
        exp_rd  = (bus_addr == 3'd0) ? ref_sts : (bus_addr == 3'd4) ? ref_msk : 0;
        exp_irq = ((ref_sts & ref_msk) != 0);
        n_cmp++;
        if (bus_rdata !== exp_rd) begin
            n_bad++;
            $display("FAIL %s rdata addr %0d: actual %h expected %h", req, bus_addr, bus_rdata, exp_rd);
        end
        n_cmp++;
        if (irq_o !== exp_irq) begin
            n_bad++;
            $display("FAIL %s irq: actual %b expected %b", req, irq_o, exp_irq);
        end
    endtask

    task automatic step(input logic wr, input logic [2:0] a, input logic [31:0] d, input logic [4:0] ev);
        @(negedge clk);
        bus_wr = wr; bus_addr = a; bus_wdata = d; src_pulse = ev;
        #1 compare();
    endtask

    task automatic idle(input logic [2:0] a);
        step(1'b0, a, 32'h0, 5'h0);
    endtask

    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        req = "R1";
        repeat (3) idle(3'd0);
        rst_n = 1'b1;
        idle(3'd0); idle(3'd4);

        req = "R10";
        step(1'b1, 3'd0, 32'hffff_ffff, 5'h0); idle(3'd0);
        req = "R7";
        step(1'b1, 3'd4, 32'hffff_ffff, 5'h0); idle(3'd4);
        req = "R9";
        for (int a = 5; a < 8; a++) step(1'b1, a[2:0], 32'hffff_ffff, 5'h0);
        for (int a = 0; a < 8; a++) idle(a[2:0]);

        req = "R2";
        for (int i = 0; i < 5; i++) begin
            step(1'b0, 3'd0, 32'h0, 5'(1 << i));
            idle(3'd0);
        end
        idle(3'd0);

        req = "R5";
        step(1'b1, 3'd2, 32'hffff_ffe5, 5'h0); idle(3'd4);
        step(1'b1, 3'd2, 32'h0, 5'h0); idle(3'd4);
        req = "R8";
        idle(3'd0);
        req = "R6";
        step(1'b1, 3'd3, 32'h0000_0001, 5'h0); idle(3'd4);
        step(1'b1, 3'd3, 32'h0, 5'h0); idle(3'd4);

        req = "R3";
        step(1'b1, 3'd1, 32'h0000_000a, 5'h0); idle(3'd0);
        step(1'b1, 3'd1, 32'h0, 5'h0); idle(3'd0);
        req = "R4";
        step(1'b1, 3'd1, 32'h0000_001f, 5'h10); idle(3'd0);
        req = "R8";
        step(1'b1, 3'd1, 32'h1f, 5'h0); idle(3'd0);
        step(1'b0, 3'd0, 32'h0, 5'h04); idle(3'd4);
        step(1'b1, 3'd3, 32'h1f, 5'h0); idle(3'd0);

        req = "R8";
        for (int k = 0; k < 2000; k++)
            step(($urandom % 3) == 0, 3'($urandom), $urandom, 5'($urandom) & 5'($urandom));

        req = "R1";
        @(negedge clk); rst_n = 1'b0;
        idle(3'd0); idle(3'd0);
        rst_n = 1'b1;
        idle(3'd4); idle(3'd0);

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule